// File: doc/BRIEF.md
# Multiprocessor-Filtered Serial Receiver

This block receives asynchronous serial frames on one input line and places each byte in a data register. Flags report a held byte, a bad stop bit, or a byte lost because the register was still full. A sample-rate enable is derived from the system clock by a prescaler with four selectable division ratios. The line is sampled at 16 ticks per bit. A start bit counts only if the line is still low half a bit after the falling edge.

In multiprocessor framing mode, each frame carries one extra flag bit between the data bits and the stop bit. A bit of 1 marks an address frame and a bit of 0 marks a data frame. The host can arm a wake filter. While the filter is armed, data frames vanish without touching any status flag. The first address frame clears the filter and is received normally, so the host wakes only when another node addresses it. The flag bit of the last accepted frame is readable, so the host can tell address frames from data frames.

Top module: `mp_serial_rx`

## Requirements
- R1: After reset, rxData is 0x00 and rxFull, frameErr, overrun, mpFlag, wakeArmed, rxIrq and errIrq are all 0.
- R2: A frame is laid out as follows: a start bit of 0, then 8 data bits sent LSB first, then (only when mpMode=1) one multiprocessor bit, then a stop bit of 1. The line idles at 1. An accepted frame with a good stop bit and rxFull=0 loads rxData, sets rxFull, and copies its multiprocessor bit to mpFlag (0 when mpMode=0).
- R3: clkSel selects the sample tick rate: 00 gives every clock, 01 every 8th clock, 10 every 32nd clock and 11 every 128th clock. One bit lasts 16 ticks.
- R4: A low pulse on rxLine that is gone before the half-bit sample (8 ticks) is ignored and produces no frame.
- R5: While rxEnable=0, frames on the line change no flag and no data.
- R6: An accepted frame whose stop bit is sampled as 0 sets frameErr and leaves rxData and rxFull unchanged.
- R7: An accepted frame with a good stop bit that completes while rxFull=1 sets overrun and leaves rxData unchanged.
- R8: While wakeArmed=1 and mpMode=1, a frame whose multiprocessor bit is 0 changes none of rxFull, frameErr, overrun, rxData or mpFlag, even when its stop bit is bad.
- R9: While wakeArmed=1 and mpMode=1, a frame whose multiprocessor bit is 1 clears wakeArmed and is received normally. Later frames with a multiprocessor bit of 0 are then accepted.
- R10: A one-cycle armSet strobe sets wakeArmed. While mpMode=0 the filter drops nothing and wakeArmed stays set.
- R11: rxIrq is 1 exactly when rxIntEn=1 and rxFull=1. errIrq is 1 exactly when rxIntEn=1 and frameErr or overrun is 1.
- R12: rxFull, frameErr and overrun stay set until their own one-cycle clear strobe (clrFull, clrFrameErr, clrOverrun).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial receive line, idles high |
| clkSel | input | 2 | Prescaler ratio select |
| rxEnable | input | 1 | Receive enable |
| rxIntEn | input | 1 | Receive and error interrupt enable |
| mpMode | input | 1 | Multiprocessor framing select |
| armSet | input | 1 | One-cycle strobe that arms the wake filter |
| clrFull | input | 1 | One-cycle clear of rxFull |
| clrFrameErr | input | 1 | One-cycle clear of frameErr |
| clrOverrun | input | 1 | One-cycle clear of overrun |
| rxData | output | 8 | Last accepted data byte |
| rxFull | output | 1 | Data register holds an unread byte |
| frameErr | output | 1 | Stop bit was sampled low |
| overrun | output | 1 | A byte was lost while rxFull was set |
| mpFlag | output | 1 | Multiprocessor bit of the last loaded frame |
| wakeArmed | output | 1 | Wake filter is armed |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Receive error interrupt request |

## Verification
The bench checks the filter in both directions.
- Data frames sent while the filter is armed, including one with a broken stop bit, must leave every flag alone. A filter that still updates flags would show frameErr or rxFull.
- The address frame that disarms the filter must itself be loaded. A design that drops it loses the byte that wakes the host.
- With the filter armed but multiprocessor framing off, an 8-bit frame must pass. A design that ignores the mode would drop it or misread the stop bit.

Sampling is tested as well.
- A short low glitch must not start a frame.
- A frame that completes while the register is full must set overrun and keep the old byte.
- Frames are also sent at the slower prescaler ratios. A wrong divider would shift the sample point and corrupt the bytes.

// File: rtl/mp_serial_rx_pkg.sv
package mp_serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_MP,
    ST_STOP
  } rxState_t;

  // Strobes from the bit sequencer to the datapath
  typedef struct packed {
    logic shiftIn;    // a data bit is valid on bitVal
    logic mpLoad;     // the multiprocessor bit is valid on bitVal
    logic frameDone;  // the stop bit is valid on bitVal
    logic bitVal;     // the sampled line level
  } rxStrobe_t;

  localparam int PRE_W = 7;

  // Division ratios 1, 8, 32 and 128, returned as terminal count
  function automatic logic [PRE_W-1:0] divLimit(input logic [1:0] sel);
    logic [PRE_W:0] full;
    full = '0;
    if (sel == 2'd0) return '0;
    full[2*sel+1] = 1'b1;
    return PRE_W'(full - 1'b1);
  endfunction

endpackage

// File: rtl/mp_serial_rx_prescale.sv
module mp_serial_rx_prescale
  import mp_serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] clkSel,
  output logic       tick
);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] lim;

  assign lim  = divLimit(clkSel);
  assign tick = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rstN)     cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R3: for any ratio above one, ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (tick && clkSel != 2'd0 && $stable(clkSel)) |=> !tick);

endmodule

// File: rtl/mp_serial_rx_ctrl.sv
module mp_serial_rx_ctrl
  import mp_serial_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       tick,
  input  logic       rxEnable,
  input  logic       mpMode,
  output rxStrobe_t  strobe
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OVERSAMPLE/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic             lineS1, lineS2;
  logic             run, midBit;

  assign run    = tick && rxEnable;
  assign midBit = run && (cnt == LAST_CNT);

  // Two-stage synchronizer, idles high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineS1 <= 1'b1;
      lineS2 <= 1'b1;
    end else begin
      lineS1 <= rxLine;
      lineS2 <= lineS1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (!rxEnable) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          cnt    <= '0;
          bitIdx <= '0;
          if (!lineS2) state <= ST_START;
        end
        ST_START: begin
          if (cnt == HALF_CNT) begin
            cnt   <= '0;
            state <= lineS2 ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == LAST_CNT) begin
            cnt <= '0;
            if (bitIdx == LAST_IDX) begin
              bitIdx <= '0;
              state  <= mpMode ? ST_MP : ST_STOP;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_MP: begin
          if (cnt == LAST_CNT) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == LAST_CNT) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.bitVal    = lineS2;
    strobe.shiftIn   = midBit && (state == ST_DATA);
    strobe.mpLoad    = midBit && (state == ST_MP);
    strobe.frameDone = midBit && (state == ST_STOP);
  end

  // R5: dropping the enable returns the sequencer to idle
  a_r5_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> state == ST_IDLE);

  // R2: at most one sample strobe per cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftIn, strobe.mpLoad, strobe.frameDone}));

  // R10: without multiprocessor framing the flag-bit slot is never entered
  a_r10_no_mp_slot: assert property (@(posedge clk) disable iff (!rstN)
    (!mpMode && state != ST_MP) |=> state != ST_MP);

endmodule

// File: rtl/mp_serial_rx_datapath.sv
module mp_serial_rx_datapath
  import mp_serial_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strobe,
  input  logic                 mpMode,
  input  logic                 armSet,
  input  logic                 clrFull,
  input  logic                 clrFrameErr,
  input  logic                 clrOverrun,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 frameErr,
  output logic                 overrun,
  output logic                 mpFlag,
  output logic                 wakeArmed
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 mpNew;
  logic                 filterOn, dropFrame, acceptFrame;

  assign filterOn    = wakeArmed && mpMode;
  assign dropFrame   = filterOn && !mpNew;
  assign acceptFrame = strobe.frameDone && !dropFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      mpNew    <= 1'b0;
    end else begin
      if (strobe.shiftIn) shiftReg <= {strobe.bitVal, shiftReg[DATA_BITS-1:1]};
      if (strobe.mpLoad)  mpNew <= strobe.bitVal;
      else if (strobe.frameDone) mpNew <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeArmed <= 1'b0;
    end else if (armSet) begin
      wakeArmed <= 1'b1;
    end else if (strobe.frameDone && filterOn && mpNew) begin
      wakeArmed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData   <= '0;
      rxFull   <= 1'b0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
      mpFlag   <= 1'b0;
    end else begin
      if (clrFull)     rxFull   <= 1'b0;
      if (clrFrameErr) frameErr <= 1'b0;
      if (clrOverrun)  overrun  <= 1'b0;
      if (acceptFrame) begin
        if (!strobe.bitVal) begin
          frameErr <= 1'b1;
        end else if (rxFull) begin
          overrun <= 1'b1;
        end else begin
          rxData <= shiftReg;
          rxFull <= 1'b1;
          mpFlag <= mpNew;
        end
      end
    end
  end

  // R8: a filtered frame leaves every status flag and the data alone
  a_r8_filtered_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && wakeArmed && mpMode && !mpNew &&
     !clrFull && !clrFrameErr && !clrOverrun)
    |=> ($stable(rxFull) && $stable(frameErr) && $stable(overrun) &&
         $stable(rxData) && $stable(mpFlag)));

  // R9: an address frame disarms the filter
  a_r9_disarm: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && wakeArmed && mpMode && mpNew && !armSet) |=> !wakeArmed);

  // R7: overrun never replaces the held byte
  a_r7_keep_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $stable(rxData));

  // R12: receive-full holds until cleared
  a_r12_full_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !clrFull) |=> rxFull);

  // R12: framing error holds until cleared
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !clrFrameErr) |=> frameErr);

endmodule

// File: rtl/mp_serial_rx.sv
module mp_serial_rx
  import mp_serial_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic [1:0]           clkSel,
  input  logic                 rxEnable,
  input  logic                 rxIntEn,
  input  logic                 mpMode,
  input  logic                 armSet,
  input  logic                 clrFull,
  input  logic                 clrFrameErr,
  input  logic                 clrOverrun,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 frameErr,
  output logic                 overrun,
  output logic                 mpFlag,
  output logic                 wakeArmed,
  output logic                 rxIrq,
  output logic                 errIrq
);

  logic      tick;
  rxStrobe_t strobe;

  mp_serial_rx_prescale u_prescale (
    .clk    (clk),
    .rstN   (rstN),
    .clkSel (clkSel),
    .tick   (tick)
  );

  mp_serial_rx_ctrl #(
    .DATA_BITS  (DATA_BITS),
    .OVERSAMPLE (OVERSAMPLE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .tick     (tick),
    .rxEnable (rxEnable),
    .mpMode   (mpMode),
    .strobe   (strobe)
  );

  mp_serial_rx_datapath #(
    .DATA_BITS (DATA_BITS)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .mpMode      (mpMode),
    .armSet      (armSet),
    .clrFull     (clrFull),
    .clrFrameErr (clrFrameErr),
    .clrOverrun  (clrOverrun),
    .rxData      (rxData),
    .rxFull      (rxFull),
    .frameErr    (frameErr),
    .overrun     (overrun),
    .mpFlag      (mpFlag),
    .wakeArmed   (wakeArmed)
  );

  assign rxIrq  = rxIntEn && rxFull;
  assign errIrq = rxIntEn && (frameErr || overrun);

  // R11: no request of either kind while the enable is low
  a_r11_masked: assert property (@(posedge clk) disable iff (!rstN)
    !rxIntEn |-> (!rxIrq && !errIrq));

endmodule

// File: tb/mp_serial_rx_bench.sv
module mp_serial_rx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic [1:0] clkSel = 2'd0;
  logic       rxEnable = 1'b0, rxIntEn = 1'b0, mpMode = 1'b0, armSet = 1'b0;
  logic       clrFull = 1'b0, clrFrameErr = 1'b0, clrOverrun = 1'b0;
  logic [7:0] rxData;
  logic       rxFull, frameErr, overrun, mpFlag, wakeArmed, rxIrq, errIrq;

  int checks = 0, errors = 0;
  int monChecks = 0, monErrors = 0;
  bit done = 1'b0;
  logic [8:0] expQ[$];   // {mpBit, data}
  logic prevFull = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mp_serial_rx u_mp_serial_rx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .clkSel(clkSel),
    .rxEnable(rxEnable), .rxIntEn(rxIntEn), .mpMode(mpMode), .armSet(armSet),
    .clrFull(clrFull), .clrFrameErr(clrFrameErr), .clrOverrun(clrOverrun),
    .rxData(rxData), .rxFull(rxFull), .frameErr(frameErr), .overrun(overrun),
    .mpFlag(mpFlag), .wakeArmed(wakeArmed), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  // Monitor: every newly loaded byte is compared with the scoreboard head (R2)
  always @(negedge clk) begin
    if (rstN && rxFull && !prevFull) begin
      monChecks <= monChecks + 1;
      if (expQ.size() == 0) begin
        monErrors <= monErrors + 1;
        $display("FAIL R2: unexpected byte act=%h/%b exp=none", rxData, mpFlag);
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        if ({mpFlag, rxData} !== e) begin
          monErrors <= monErrors + 1;
          $display("FAIL R2: loaded byte act=%b/%h exp=%b/%h", mpFlag, rxData, e[8], e[7:0]);
        end
      end
    end
    prevFull <= rxFull;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: sends one frame; expected results enter the scoreboard
  task automatic sendFrame(input logic [7:0] data, input logic mpBit,
                           input logic stopBit, input int div, input bit expectLoad);
    int bitLen;
    bitLen = 16 * div;
    if (expectLoad) expQ.push_back({mpMode ? mpBit : 1'b0, data});
    rxLine = 1'b0; idle(bitLen);
    for (int i = 0; i < 8; i++) begin
      rxLine = data[i]; idle(bitLen);
    end
    if (mpMode) begin
      rxLine = mpBit; idle(bitLen);
    end
    rxLine = stopBit; idle(bitLen);
    rxLine = 1'b1; idle(bitLen);
  endtask

  task automatic clearAll();
    clrFull = 1'b1; clrFrameErr = 1'b1; clrOverrun = 1'b1;
    idle(1);
    clrFull = 1'b0; clrFrameErr = 1'b0; clrOverrun = 1'b0;
    idle(2);
  endtask

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    check("R1", {rxData, rxFull, frameErr, overrun, mpFlag, wakeArmed, rxIrq, errIrq}, 32'h0);

    rxEnable = 1'b1;
    // R2 plain 8-bit frame
    sendFrame(8'hA5, 1'b0, 1'b1, 1, 1'b1);
    check("R2", rxFull, 1'b1);
    // R11 request follows enable
    check("R11", rxIrq, 1'b0);
    rxIntEn = 1'b1; idle(1);
    check("R11", rxIrq, 1'b1);
    check("R11", errIrq, 1'b0);

    // R7 overrun keeps old byte
    sendFrame(8'h3C, 1'b0, 1'b1, 1, 1'b0);
    check("R7", overrun, 1'b1);
    check("R7", rxData, 8'hA5);
    check("R11", errIrq, 1'b1);
    // R12 sticky flags
    idle(50);
    check("R12", {rxFull, overrun}, 2'b11);
    clearAll();
    check("R12", {rxFull, overrun, frameErr}, 3'b000);

    // R6 bad stop bit
    sendFrame(8'h11, 1'b0, 1'b0, 1, 1'b0);
    check("R6", frameErr, 1'b1);
    check("R6", rxFull, 1'b0);
    check("R6", rxData, 8'hA5);
    clearAll();

    // R4 short glitch
    rxLine = 1'b0; idle(4); rxLine = 1'b1; idle(200);
    check("R4", {rxFull, frameErr}, 2'b00);
    sendFrame(8'h5A, 1'b0, 1'b1, 1, 1'b1);
    check("R4", rxFull, 1'b1);
    clearAll();

    // R5 disabled receiver
    rxEnable = 1'b0;
    sendFrame(8'h77, 1'b0, 1'b0, 1, 1'b0);
    check("R5", {rxFull, frameErr, overrun}, 3'b000);
    check("R5", rxData, 8'h5A);
    rxEnable = 1'b1; idle(4);

    // R10 armed filter without multiprocessor framing
    armSet = 1'b1; idle(1); armSet = 1'b0; idle(1);
    check("R10", wakeArmed, 1'b1);
    sendFrame(8'h42, 1'b0, 1'b1, 1, 1'b1);
    check("R10", {rxFull, wakeArmed, mpFlag}, 3'b110);
    clearAll();

    // R8 filtered data frames
    mpMode = 1'b1; idle(2);
    sendFrame(8'h99, 1'b0, 1'b1, 1, 1'b0);
    check("R8", {rxFull, frameErr, overrun, wakeArmed}, 4'b0001);
    check("R8", rxData, 8'h42);
    sendFrame(8'h66, 1'b0, 1'b0, 1, 1'b0);
    check("R8", {rxFull, frameErr, overrun, wakeArmed}, 4'b0001);

    // R9 address frame wakes and loads
    sendFrame(8'h21, 1'b1, 1'b1, 1, 1'b1);
    check("R9", {rxFull, wakeArmed, mpFlag}, 3'b101);
    check("R9", rxData, 8'h21);
    clearAll();
    sendFrame(8'h33, 1'b0, 1'b1, 1, 1'b1);
    check("R9", {rxFull, mpFlag}, 2'b10);
    clearAll();

    // R3 slower prescaler ratios
    mpMode = 1'b0;
    clkSel = 2'd1; idle(4);
    sendFrame(8'hC3, 1'b0, 1'b1, 8, 1'b1);
    check("R3", {rxFull, rxData}, {1'b1, 8'hC3});
    clearAll();
    clkSel = 2'd2; idle(4);
    sendFrame(8'hF0, 1'b0, 1'b1, 32, 1'b1);
    check("R3", {rxFull, rxData}, {1'b1, 8'hF0});
    clearAll();
    clkSel = 2'd3; idle(4);
    sendFrame(8'h0F, 1'b0, 1'b1, 128, 1'b1);
    check("R3", {rxFull, rxData}, {1'b1, 8'h0F});
    clearAll();

    check("R2", expQ.size(), 0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=timeout exp=completion");
    end
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors",
             checks + monChecks, errors + monErrors);
    $finish;
  end

endmodule